// File: doc/BRIEF.md
# HDLC FIFO Status and Interrupt Register

This block is the status word of an HDLC controller that has a 256-byte transmit FIFO and a receive FIFO. It takes two kinds of input. The first is the live transmit FIFO occupancy, which it reports continuously as a 16-byte bucket code and an empty flag. The second is a set of single-cycle event pulses: receive message end, transmit underrun and receive overrun. Each event pulse is held in a sticky bit until the register is read.

Reading the register returns the current word on the same cycle. That read clears every sticky bit at the next clock edge. An event that arrives in the same cycle as a read is not lost.

The underrun and overrun bits re-arm only once their FIFO has left the fault condition. For underrun that means the FIFO has been written; for overrun it means the FIFO has been read. A repeated fault pulse without that step is therefore not reported twice.

The interrupt line is the OR of the sticky bits, each gated by its own mask bit. The result is also gated by a master HDLC enable.

Top module: `hdlc_stat_reg`

## Requirements
- R1: `stat_rdata[11:8]` shows the transmit level code. The code is `tx_level/16` for levels 0 to 255, and 15 for a level of 256.
- R2: `stat_rdata[12]` is 1 exactly when `tx_level` is 0.
- R3: `stat_rdata[6]` (message end) becomes 1 on the clock edge where `rx_pkt_end` is high. It becomes 0 on the edge where `rd_stat` is high, unless a new message end arrives on that same edge.
- R4: `stat_rdata[7]` (underrun) becomes 1 on the edge where `tx_underrun` is high, provided the underrun detector is armed. A read clears it.
- R5: Once an underrun has been latched, further `tx_underrun` pulses are ignored until a `tx_wr` pulse has been seen.
- R6: `stat_rdata[13]` (overrun) latches on `rx_overrun` while armed and is cleared by a read. After it has latched, further pulses are ignored until an `rx_rd` pulse has been seen.
- R7: An event on the same edge as `rd_stat` leaves its bit at 1 after that edge.
- R8: `irq` is 1 when `mst_hdlc_en` is 1 and at least one sticky bit is 1 with its own mask bit at 1 (`msk_pkt_end`, `msk_underrun`, `msk_overrun`). Otherwise `irq` is 0.
- R9: The level code and the empty flag never cause `irq`.
- R10: Both re-arm detectors are armed out of reset, so the first underrun and the first overrun after reset are reported.
- R11: The reset state has every sticky bit at 0. All bits of `stat_rdata` other than 6 to 13 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level | input | 9 | Transmit FIFO occupancy in bytes (0..256) |
| tx_wr | input | 1 | Transmit FIFO write strobe |
| rx_rd | input | 1 | Receive FIFO read strobe |
| rx_pkt_end | input | 1 | Receive message-end event pulse |
| tx_underrun | input | 1 | Transmit FIFO underrun event pulse |
| rx_overrun | input | 1 | Receive FIFO overrun event pulse |
| rd_stat | input | 1 | Status register read strobe |
| msk_pkt_end | input | 1 | Interrupt enable for message end |
| msk_underrun | input | 1 | Interrupt enable for underrun |
| msk_overrun | input | 1 | Interrupt enable for overrun |
| mst_hdlc_en | input | 1 | Master HDLC interrupt enable |
| stat_rdata | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The level code and the empty flag are combinational from `tx_level`. The bench therefore checks them in the same cycle the level is applied, at the falling edge. Sticky bits and the re-arm state change on the rising edge where their strobe is high. Their effect on `stat_rdata` and `irq` is due one edge later, and the bench always samples at the falling edge that follows. The mask and master enable inputs act on `irq` with no register in between, so those checks are made in the same half-cycle in which the masks change.

// File: rtl/hdlc_stat_reg.sv
module hdlc_stat_reg #(
  parameter int LVL_W       = 9,
  parameter int BUCKET_LOG2 = 4,
  parameter int CODE_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_wr,
  input  logic             rx_rd,
  input  logic             rx_pkt_end,
  input  logic             tx_underrun,
  input  logic             rx_overrun,
  input  logic             rd_stat,
  input  logic             msk_pkt_end,
  input  logic             msk_underrun,
  input  logic             msk_overrun,
  input  logic             mst_hdlc_en,
  output logic [15:0]      stat_rdata,
  output logic             irq
);
  localparam logic [LVL_W-1:0] CODE_MAX = LVL_W'((1 << CODE_W) - 1);

  logic pkt_q, ur_q, ovr_q, ur_arm, ovr_arm;
  logic [LVL_W-1:0] bucket;
  logic [CODE_W-1:0] code;

  assign bucket = tx_level >> BUCKET_LOG2;
  assign code   = (bucket > CODE_MAX) ? CODE_MAX[CODE_W-1:0] : bucket[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_q   <= 1'b0;
      ur_q    <= 1'b0;
      ovr_q   <= 1'b0;
      ur_arm  <= 1'b1;
      ovr_arm <= 1'b1;
    end else begin
      pkt_q   <= (pkt_q & ~rd_stat) | rx_pkt_end;
      ur_q    <= (ur_q  & ~rd_stat) | (tx_underrun & ur_arm);
      ovr_q   <= (ovr_q & ~rd_stat) | (rx_overrun  & ovr_arm);
      ur_arm  <= tx_wr | (ur_arm  & ~tx_underrun);
      ovr_arm <= rx_rd | (ovr_arm & ~rx_overrun);
    end
  end

  always_comb begin
    stat_rdata        = '0;
    stat_rdata[6]     = pkt_q;
    stat_rdata[7]     = ur_q;
    stat_rdata[11:8]  = code;
    stat_rdata[12]    = (tx_level == '0);
    stat_rdata[13]    = ovr_q;
  end

  assign irq = mst_hdlc_en &
               ((pkt_q & msk_pkt_end) | (ur_q & msk_underrun) | (ovr_q & msk_overrun));

  p_event_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pkt_end |=> stat_rdata[6]);
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !rx_pkt_end) |=> !stat_rdata[6]);
  p_no_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ur_arm && !tx_wr) |=> !stat_rdata[7]);
  p_ovr_no_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ovr_arm && !rx_rd) |=> !stat_rdata[13]);
  p_empty_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[12] |-> (stat_rdata[11:8] == 4'd0));
  p_master_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mst_hdlc_en && (stat_rdata[6] || stat_rdata[7] || stat_rdata[13])));
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[5:0] == 6'd0) && (stat_rdata[15:14] == 2'd0));
endmodule

// File: tb/hdlc_stat_reg_test.sv
module hdlc_stat_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] tx_level = '0;
  logic tx_wr = 0, rx_rd = 0, rx_pkt_end = 0, tx_underrun = 0, rx_overrun = 0, rd_stat = 0;
  logic msk_pkt_end = 1, msk_underrun = 1, msk_overrun = 1, mst_hdlc_en = 1;
  logic [15:0] stat_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hdlc_stat_reg uut (.*);

  localparam int NV = 10;
  localparam logic [8:0] LV  [NV] = '{9'd0, 9'd1, 9'd15, 9'd16, 9'd31, 9'd100, 9'd239, 9'd240, 9'd255, 9'd256};
  localparam logic [3:0] EXP [NV] = '{4'd0, 4'd0, 4'd0, 4'd1, 4'd1, 4'd6, 4'd14, 4'd15, 4'd15, 4'd15};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: rx_pkt_end = 1;  1: tx_underrun = 1; 2: rx_overrun = 1;
      3: rd_stat = 1;     4: tx_wr = 1;       5: rx_rd = 1;
      6: begin rx_pkt_end = 1; rd_stat = 1; end
      default: ;
    endcase
    @(posedge clk); #1;
    {rx_pkt_end, tx_underrun, rx_overrun, rd_stat, tx_wr, rx_rd} = '0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R11 reset word", stat_rdata, 32'h1000);
    chk("R11 reset irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      tx_level = LV[i];
      @(negedge clk);
      chk("R1 level code", stat_rdata[11:8], EXP[i]);
      chk("R2 empty flag", stat_rdata[12], LV[i] == 0);
      chk("R9 level no irq", irq, 0);
      chk("R11 reserved", stat_rdata & 16'hC03F, 0);
    end
    tx_level = 0;

    pulse(0);
    chk("R3 pkt end latched", stat_rdata[6], 1);
    chk("R8 irq all enabled", irq, 1);
    mst_hdlc_en = 0; #1;
    chk("R8 master off", irq, 0);
    mst_hdlc_en = 1; msk_pkt_end = 0; #1;
    chk("R8 bit mask off", irq, 0);
    msk_pkt_end = 1; #1;
    pulse(3);
    chk("R3 read clears", stat_rdata[6], 0);
    chk("R3 irq released", irq, 0);
    pulse(6);
    chk("R7 event during read kept", stat_rdata[6], 1);
    pulse(3);
    chk("R9 empty no irq", irq, 0);

    pulse(1);
    chk("R10 R4 first underrun", stat_rdata[7], 1);
    pulse(3);
    chk("R4 read clears underrun", stat_rdata[7], 0);
    pulse(1);
    chk("R5 no rearm without write", stat_rdata[7], 0);
    pulse(4);
    pulse(1);
    chk("R5 rearmed after write", stat_rdata[7], 1);
    chk("R8 underrun irq", irq, 1);
    pulse(3);

    pulse(2);
    chk("R10 R6 first overrun", stat_rdata[13], 1);
    msk_overrun = 0; #1;
    chk("R8 overrun masked", irq, 0);
    msk_overrun = 1;
    pulse(3);
    chk("R6 read clears overrun", stat_rdata[13], 0);
    pulse(2);
    chk("R6 no rearm without read", stat_rdata[13], 0);
    pulse(5);
    pulse(2);
    chk("R6 rearmed after read", stat_rdata[13], 1);
    chk("R11 reserved", stat_rdata & 16'hC03F, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule